// File: doc/BRIEF.md
# Timer Counter Clock Source and Clear Control

This block is one timer channel built around a 16-bit up-counter. A 7-bit control word selects where the counter's clock comes from, which edges count, and what resets the counter to zero. There are eight count sources. Four are internal, taken from a free-running prescaler as single-cycle enable pulses at the system rate and at one half, one quarter and one eighth of it. The other four are external pins, and each is synchronised and then qualified by edge. The count never runs on a derived clock. Everything runs on one clock and changes state on its rising edge.

The channel has two general registers, A and B. Each one works either as a compare register or as a capture register. As a compare register it signals a match while the counter equals its value. As a capture register it stores the counter value on a synchronised rising edge of its own capture pin. Either register's event can be chosen to clear the counter. A third choice is a group clear pulse from a controller shared by sibling channels. When the channel is in phase-counting mode, an external decoder supplies the count steps, and clock select and edge select are both bypassed.

Each external and capture pin passes through a two-stage synchroniser into a small level-tracking state machine. The machine has two states, `LVL_LO` and `LVL_HI`. It moves from `LVL_LO` to `LVL_HI` when the synchronised level is 1, which is a rise. It moves from `LVL_HI` to `LVL_LO` when the level is 0, which is a fall. In any other case it holds its state. The machine issues a one-cycle event on the transitions that the selected edge mode accepts.

Top module: `tmr_chan_clkclr`

## Requirements
- R1: While reset is asserted, the control word is 0, the counter is 0, both general registers read 0xFFFF, and `ovf` is 0. Control word 0 means no clear, rising edge, and the undivided internal clock.
- R2: Clock select (control bits 2:0) values 000, 001, 010 and 011 count every cycle, every 2nd, every 4th and every 8th cycle. Over any 64 consecutive cycles the counter therefore advances by 64, 32, 16 or 8.
- R3: Clock select values 100, 101, 110 and 111 count edges on `ext_clk[0]`, `ext_clk[1]`, `ext_clk[2]` and `ext_clk[3]`. Activity on the pins that are not selected does not change the counter.
- R4: Edge select (control bits 4:3) applies to external sources. 00 counts rising edges, 01 counts falling edges, and 10 or 11 counts both. A pin change reaches the counter on the third rising clock edge after it.
- R5: While `phase_mode` is 1, the counter advances by one for each cycle in which `phase_step` is 1, and for nothing else. Clock select and edge select are then ignored.
- R6: Clear select (control bits 6:5) value 00 never clears the counter, even while a compare match is present.
- R7: Clear select 01 clears on general register A's event and 10 clears on register B's event. For a compare register holding G, counting every cycle, the counter repeats 0, 1, ..., G.
- R8: A capture register loads the counter value from the cycle before the capture edge (two cycles after the pin rises). If that register also clears the counter, the counter is 0 on the same edge.
- R9: `sync_clr` clears the counter on the next edge only when clear select is 11. Under any other selection it has no effect.
- R10: When a clear and a count step fall in the same cycle, the counter becomes 0.
- R11: The counter wraps from 0xFFFF to 0x0000. `ovf` is 1 for exactly the one cycle in which the counter holds the wrapped value 0.
- R12: `cmp_match[i]` is 1 while the counter equals general register i in compare mode (`gr_is_cap[i]`=0). It is always 0 in capture mode, and a capture register causes no clear on equality.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 7 | Control word: [6:5] clear select, [4:3] edge select, [2:0] clock select |
| ctl_q | output | 7 | Current control word |
| gr_we | input | 2 | Write strobes for general registers A (bit 0) and B (bit 1) |
| gr_wdata | input | 16 | Write data shared by both general registers |
| gr_is_cap | input | 2 | Per register: 1 = capture mode, 0 = compare mode |
| cap_in | input | 2 | Capture pins for registers A and B |
| ext_clk | input | 4 | External clock pins for sources 100 to 111 |
| phase_mode | input | 1 | Phase-counting mode active |
| phase_step | input | 1 | One-cycle count step from the phase decoder |
| sync_clr | input | 1 | One-cycle group clear pulse |
| cnt_q | output | 16 | Counter value |
| gra_q | output | 16 | General register A |
| grb_q | output | 16 | General register B |
| cmp_match | output | 2 | Compare equality per general register |
| ovf | output | 1 | One-cycle wrap flag |

## Verification
The two functions that share a cycle are the count step and the clear, and in capture mode also the capture and the clear. The bench provokes the first collision by running the counter at full rate against a compare value, so that the clear lands on a counting edge. It judges the result by the repeating sequence 0..G computed as the cycle index modulo G+1. The second collision uses a capture register that is also the clear source. The bench then expects the register to hold the counter value from two cycles after the pin rise, and the counter to read 0 on that same edge.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

    typedef enum logic [1:0] {
        CLR_NONE = 2'b00,
        CLR_GRA  = 2'b01,
        CLR_GRB  = 2'b10,
        CLR_SYNC = 2'b11
    } clr_sel_e;

    typedef enum logic [1:0] {
        EDG_RISE     = 2'b00,
        EDG_FALL     = 2'b01,
        EDG_BOTH     = 2'b10,
        EDG_BOTH_ALT = 2'b11
    } edge_sel_e;

    typedef enum logic {
        LVL_LO = 1'b0,
        LVL_HI = 1'b1
    } lvl_state_e;

    typedef struct packed {
        clr_sel_e  clr;
        edge_sel_e edg;
        logic [2:0] src;
    } ctl_t;

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int N_TAPS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [N_TAPS-1:0] tick
);
    localparam int PW = (N_TAPS > 1) ? N_TAPS - 1 : 1;

    logic [PW-1:0] pdiv_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pdiv_q <= '0;
        else        pdiv_q <= pdiv_q + 1'b1;
    end

    assign tick[0] = 1'b1;

    generate
        for (genvar k = 1; k < N_TAPS; k++) begin : g_tap
            assign tick[k] = &pdiv_q[k-1:0];
        end
    endgenerate

endmodule

// File: rtl/tmr_edge_qual.sv
module tmr_edge_qual
    import tmr_chan_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pin,
    input  edge_sel_e mode,
    output logic      evt
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   lvl;
    lvl_state_e             state_q, state_d;
    logic                   rise, fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
    end

    assign lvl = sync_q[SYNC_STAGES-1];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LVL_LO;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        rise    = 1'b0;
        fall    = 1'b0;
        unique case (state_q)
            LVL_LO: if (lvl) begin
                state_d = LVL_HI;
                rise    = 1'b1;
            end
            LVL_HI: if (!lvl) begin
                state_d = LVL_LO;
                fall    = 1'b1;
            end
        endcase
    end

    always_comb begin
        unique case (mode)
            EDG_RISE:     evt = rise;
            EDG_FALL:     evt = fall;
            EDG_BOTH,
            EDG_BOTH_ALT: evt = rise | fall;
        endcase
    end

endmodule

// File: rtl/tmr_gr_unit.sv
module tmr_gr_unit #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             cap_mode,
    input  logic             cap_evt,
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] gr_q,
    output logic             match,
    output logic             clr_evt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  gr_q <= '1;
        else if (cap_mode && cap_evt) gr_q <= cnt;
        else if (wr_en)              gr_q <= wr_data;
    end

    assign match   = !cap_mode && (cnt == gr_q);
    assign clr_evt = cap_mode ? cap_evt : match;

endmodule

// File: rtl/tmr_chan_clkclr.sv
module tmr_chan_clkclr
    import tmr_chan_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [6:0]       ctl_wdata,
    output logic [6:0]       ctl_q,
    input  logic [1:0]       gr_we,
    input  logic [CNT_W-1:0] gr_wdata,
    input  logic [1:0]       gr_is_cap,
    input  logic [1:0]       cap_in,
    input  logic [3:0]       ext_clk,
    input  logic             phase_mode,
    input  logic             phase_step,
    input  logic             sync_clr,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] gra_q,
    output logic [CNT_W-1:0] grb_q,
    output logic [1:0]       cmp_match,
    output logic             ovf
);
    localparam int N_TAPS = 4;
    localparam int N_EXT  = 4;
    localparam int N_GR   = 2;

    ctl_t                ctl_r;
    logic [N_TAPS-1:0]   tick;
    logic [N_EXT-1:0]    ext_evt;
    logic [N_GR-1:0]     cap_evt;
    logic [N_GR-1:0]     gr_clr;
    logic [CNT_W-1:0]    gr_val [N_GR];
    logic                src_evt, cnt_en, clr;
    logic [CNT_W-1:0]    cnt_d;
    logic                ovf_d;

    // control word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ctl_r <= '0;
        else if (ctl_we) ctl_r <= ctl_t'(ctl_wdata);
    end
    assign ctl_q = ctl_r;

    tmr_prescale #(.N_TAPS(N_TAPS)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    generate
        for (genvar e = 0; e < N_EXT; e++) begin : g_ext
            tmr_edge_qual #(.SYNC_STAGES(SYNC_STAGES)) u_eq (
                .clk   (clk),
                .rst_n (rst_n),
                .pin   (ext_clk[e]),
                .mode  (ctl_r.edg),
                .evt   (ext_evt[e])
            );
        end
        for (genvar g = 0; g < N_GR; g++) begin : g_gr
            tmr_edge_qual #(.SYNC_STAGES(SYNC_STAGES)) u_cap (
                .clk   (clk),
                .rst_n (rst_n),
                .pin   (cap_in[g]),
                .mode  (EDG_RISE),
                .evt   (cap_evt[g])
            );
            tmr_gr_unit #(.CNT_W(CNT_W)) u_gr (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_en    (gr_we[g]),
                .wr_data  (gr_wdata),
                .cap_mode (gr_is_cap[g]),
                .cap_evt  (cap_evt[g]),
                .cnt      (cnt_q),
                .gr_q     (gr_val[g]),
                .match    (cmp_match[g]),
                .clr_evt  (gr_clr[g])
            );
        end
    endgenerate

    assign gra_q = gr_val[0];
    assign grb_q = gr_val[1];

    // count source: internal tap or qualified pin, phase steps override
    assign src_evt = ctl_r.src[2] ? ext_evt[ctl_r.src[1:0]] : tick[ctl_r.src[1:0]];
    assign cnt_en  = phase_mode ? phase_step : src_evt;

    always_comb begin
        unique case (ctl_r.clr)
            CLR_NONE: clr = 1'b0;
            CLR_GRA:  clr = gr_clr[0];
            CLR_GRB:  clr = gr_clr[1];
            CLR_SYNC: clr = sync_clr;
        endcase
    end

    always_comb begin
        cnt_d = cnt_q;
        ovf_d = 1'b0;
        if (clr) begin
            cnt_d = '0;
        end else if (cnt_en) begin
            cnt_d = cnt_q + 1'b1;
            ovf_d = &cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf   <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            ovf   <= ovf_d;
        end
    end

endmodule

// File: rtl/tmr_chan_clkclr_chk.sv
module tmr_chan_clkclr_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [6:0]       ctl_q,
    input logic [1:0]       gr_is_cap,
    input logic             phase_mode,
    input logic             phase_step,
    input logic             sync_clr,
    input logic [CNT_W-1:0] cnt_q,
    input logic [1:0]       cmp_match,
    input logic             ovf
);
    // R7
    gra_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[6:5] == 2'b01 && cmp_match[0]) |=> (cnt_q == '0));

    // R7
    grb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[6:5] == 2'b10 && cmp_match[1]) |=> (cnt_q == '0));

    // R9
    sync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[6:5] == 2'b11 && sync_clr) |=> (cnt_q == '0));

    // R6
    no_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[6:5] == 2'b00) |=> ((cnt_q >= $past(cnt_q)) || ovf));

    // R11
    ovf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> (cnt_q == '0));

    // R11
    ovf_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> !ovf);

    // R12
    cap_a_nomatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gr_is_cap[0] |-> !cmp_match[0]);

    // R12
    cap_b_nomatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gr_is_cap[1] |-> !cmp_match[1]);

    // R5
    phase_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_mode && !phase_step && ctl_q[6:5] == 2'b00) |=> $stable(cnt_q));

endmodule

bind tmr_chan_clkclr tmr_chan_clkclr_chk #(.CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_q      (ctl_q),
    .gr_is_cap  (gr_is_cap),
    .phase_mode (phase_mode),
    .phase_step (phase_step),
    .sync_clr   (sync_clr),
    .cnt_q      (cnt_q),
    .cmp_match  (cmp_match),
    .ovf        (ovf)
);

// File: tb/tmr_chan_clkclr_tb_top.sv
module tmr_chan_clkclr_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ctl_we;
    logic [6:0]  ctl_wdata;
    logic [6:0]  ctl_q;
    logic [1:0]  gr_we;
    logic [15:0] gr_wdata;
    logic [1:0]  gr_is_cap;
    logic [1:0]  cap_in;
    logic [3:0]  ext_clk;
    logic        phase_mode;
    logic        phase_step;
    logic        sync_clr;
    logic [15:0] cnt_q, gra_q, grb_q;
    logic [1:0]  cmp_match;
    logic        ovf;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    tmr_chan_clkclr dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_we     (ctl_we),
        .ctl_wdata  (ctl_wdata),
        .ctl_q      (ctl_q),
        .gr_we      (gr_we),
        .gr_wdata   (gr_wdata),
        .gr_is_cap  (gr_is_cap),
        .cap_in     (cap_in),
        .ext_clk    (ext_clk),
        .phase_mode (phase_mode),
        .phase_step (phase_step),
        .sync_clr   (sync_clr),
        .cnt_q      (cnt_q),
        .gra_q      (gra_q),
        .grb_q      (grb_q),
        .cmp_match  (cmp_match),
        .ovf        (ovf)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic wr_ctl(input logic [6:0] v);
        ctl_wdata = v;
        ctl_we    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ctl_we    = 1'b0;
    endtask

    task automatic wr_gr(input int i, input logic [15:0] v);
        gr_wdata = v;
        gr_we[i] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        gr_we    = 2'b00;
    endtask

    // stop the counter at zero: pin source A (idle), then group clear
    task automatic park();
        wr_ctl(7'b11_00_100);
        sync_clr = 1'b1;
        @(negedge clk);
        sync_clr = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_pin(input int p, input int n);
        for (int k = 0; k < n; k++) begin
            ext_clk[p] = 1'b1;
            repeat (3) @(negedge clk);
            ext_clk[p] = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            vectors++;
            fails++;
            $display("FAIL watchdog act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] c0;
        rst_n = 1'b0; ctl_we = 1'b0; ctl_wdata = '0; gr_we = '0; gr_wdata = '0;
        gr_is_cap = '0; cap_in = '0; ext_clk = '0; phase_mode = 1'b0;
        phase_step = 1'b0; sync_clr = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 ctl", ctl_q, 0);
        chk("R1 cnt", cnt_q, 0);
        chk("R1 gra", gra_q, 16'hFFFF);
        chk("R1 grb", grb_q, 16'hFFFF);
        chk("R1 ovf", ovf, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 internal prescaled sources
        for (int d = 0; d < 4; d++) begin
            wr_ctl({4'b0000, d[2:0]});
            c0 = cnt_q;
            repeat (64) @(negedge clk);
            chk($sformatf("R2 div sel %0d", d), 16'(cnt_q - c0), 64 >> d);
        end

        // R3 R4 external pins, all edge modes, unselected pins toggled
        for (int p = 0; p < 4; p++) begin
            for (int e = 0; e < 4; e++) begin
                park();
                wr_ctl({2'b00, e[1:0], 1'b1, p[1:0]});
                c0 = cnt_q;
                for (int q = 0; q < 4; q++)
                    if (q != p) pulse_pin(q, 2);
                chk($sformatf("R3 pin %0d others ignored", p), 16'(cnt_q - c0), 0);
                pulse_pin(p, 5);
                repeat (4) @(negedge clk);
                chk($sformatf("R4 pin %0d edge %0d", p, e), 16'(cnt_q - c0),
                    (e >= 2) ? 10 : 5);
            end
        end

        // R4 latency: three rising edges from pin change to count
        park();
        wr_ctl(7'b00_00_100);
        c0 = cnt_q;
        ext_clk[0] = 1'b1;
        repeat (2) @(negedge clk);
        chk("R4 latency before", 16'(cnt_q - c0), 0);
        @(negedge clk);
        chk("R4 latency at third edge", 16'(cnt_q - c0), 1);
        ext_clk[0] = 1'b0;
        repeat (4) @(negedge clk);

        // R5 phase mode overrides source and edge select
        park();
        phase_mode = 1'b1;
        for (int e = 0; e < 2; e++) begin
            wr_ctl({2'b00, (e == 0) ? 2'b00 : 2'b10, 3'b100});
            c0 = cnt_q;
            pulse_pin(0, 3);
            for (int k = 0; k < 5; k++) begin
                phase_step = 1'b1;
                @(negedge clk);
                phase_step = 1'b0;
                @(negedge clk);
            end
            repeat (4) @(negedge clk);
            chk($sformatf("R5 phase steps edge cfg %0d", e), 16'(cnt_q - c0), 5);
        end
        phase_mode = 1'b0;

        // R6 R12 no clear while matching
        park();
        gr_is_cap = 2'b00;
        wr_gr(0, 16'd3);
        wr_ctl(7'b00_00_000);
        repeat (3) @(negedge clk);
        chk("R12 match at equal", cmp_match[0], 1);
        chk("R6 cnt at 3", cnt_q, 3);
        @(negedge clk);
        chk("R12 match after", cmp_match[0], 0);
        @(negedge clk);
        chk("R6 not cleared", cnt_q, 5);

        // R7 R10 compare clear sweep on both registers
        for (int i = 0; i < 2; i++) begin
            for (int gi = 0; gi < 4; gi++) begin
                int g;
                g = (gi == 0) ? 0 : (gi == 1) ? 1 : (gi == 2) ? 4 : 9;
                park();
                gr_is_cap = 2'b00;
                wr_gr(i, 16'(g));
                wr_ctl({(i == 1), (i == 0), 5'b00_000});
                for (int j = 0; j < 24; j++) begin
                    chk($sformatf("R7 R10 gr%0d G=%0d j=%0d", i, g, j), cnt_q, j % (g + 1));
                    @(negedge clk);
                end
            end
        end

        // R8 R12 capture with and without clear
        for (int i = 0; i < 2; i++) begin
            for (int c = 0; c < 2; c++) begin
                park();
                gr_is_cap = (i == 0) ? 2'b01 : 2'b10;
                wr_gr(i, 16'd5);
                wr_ctl({(c == 1) && (i == 1), (c == 1) && (i == 0), 5'b00_000});
                repeat (5) @(negedge clk);
                chk("R12 cnt equals capture reg", cnt_q, 5);
                chk("R12 no match in capture", cmp_match[i], 0);
                @(negedge clk);
                chk("R12 no clear on equality", cnt_q, 6);
                c0 = cnt_q;
                cap_in[i] = 1'b1;
                repeat (3) @(negedge clk);
                chk($sformatf("R8 gr%0d captured clr=%0d", i, c),
                    (i == 0) ? gra_q : grb_q, 16'(c0 + 2));
                chk($sformatf("R8 gr%0d cnt clr=%0d", i, c), cnt_q,
                    (c == 1) ? 0 : 16'(c0 + 3));
                cap_in[i] = 1'b0;
                repeat (4) @(negedge clk);
            end
        end
        gr_is_cap = 2'b00;

        // R9 group clear honoured only under select 11
        park();
        wr_ctl(7'b11_00_000);
        repeat (10) @(negedge clk);
        chk("R9 running", cnt_q, 10);
        sync_clr = 1'b1;
        @(negedge clk);
        sync_clr = 1'b0;
        chk("R9 cleared under 11", cnt_q, 0);
        for (int s = 0; s < 3; s++) begin
            wr_gr(0, 16'hFFFF);
            wr_gr(1, 16'hFFFF);
            wr_ctl({s[1:0], 5'b00_000});
            c0 = cnt_q;
            sync_clr = 1'b1;
            @(negedge clk);
            sync_clr = 1'b0;
            chk($sformatf("R9 ignored under sel %0d", s), cnt_q, 16'(c0 + 1));
        end

        // R11 wrap and overflow flag
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        while (cnt_q !== 16'hFFFF) @(negedge clk);
        chk("R11 ovf before wrap", ovf, 0);
        @(negedge clk);
        chk("R11 wrapped", cnt_q, 0);
        chk("R11 ovf at wrap", ovf, 1);
        @(negedge clk);
        chk("R11 ovf one cycle", ovf, 0);
        chk("R11 after wrap", cnt_q, 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule